// File: doc/BRIEF.md
# Vector Mask Scalar-Result Unit

This block turns a mask register into one of two scalar values for a vector unit. In find-first mode it returns the index of the lowest-numbered active element whose source mask bit is set. In count mode it returns how many active elements have a set source mask bit. An element is active when its index lies in the window from vstart (inclusive) up to vl (exclusive). In masked mode, its enable-mask bit must also be 1.

The scalar destination is always written, one clock after a start strobe. This holds when vl is zero and when vstart is at or beyond vl. In those cases no element is active, so find-first yields all ones (-1) and count yields zero. Two event pulses let a performance counter count every executed operation and, separately, the operations with a non-zero vl. The block has no vector-register writeback path.

Top module: `vmask_scalar_unit`

## Requirements
- R1: With op_i = 0 (find-first), the result is the index of the lowest active element whose src_mask_i bit is 1, zero-extended to XLEN.
- R2: With op_i = 0, if no active element has a src_mask_i bit of 1, the result is all ones across XLEN bits.
- R3: With op_i = 1 (count), the result is the number of active elements whose src_mask_i bit is 1.
- R4: When vl_i is 0, wr_en_o still pulses; find-first writes all ones and count writes 0.
- R5: When vstart_i >= vl_i, wr_en_o still pulses with the empty-set results (all ones for find-first, 0 for count).
- R6: Element i is active only if vstart_i <= i < vl_i.
- R7: With masked_i = 1, an element whose en_mask_i bit is 0 is inactive; with masked_i = 0, en_mask_i has no effect on the result.
- R8: A vl_i larger than VLEN behaves as VLEN.
- R9: result_o and wr_en_o change exactly one clock after start_i; wr_en_o is high for one cycle per strobe, and result_o holds its value in cycles without a strobe.
- R10: evt_exec_o pulses together with every write, including writes with vl_i = 0; evt_vl_nz_o pulses only for operations with vl_i > 0.
- R11: After reset, wr_en_o, evt_exec_o and evt_vl_nz_o are 0 and result_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Operation strobe |
| op_i | input | 1 | 0 = find-first, 1 = count |
| masked_i | input | 1 | 1 = apply en_mask_i |
| src_mask_i | input | VLEN | Source mask |
| en_mask_i | input | VLEN | Element enable mask |
| vl_i | input | XLEN | Vector length |
| vstart_i | input | XLEN | First element index |
| result_o | output | XLEN | Scalar result |
| wr_en_o | output | 1 | Scalar write enable pulse |
| evt_exec_o | output | 1 | Executed-operation event |
| evt_vl_nz_o | output | 1 | Executed operation with vl > 0 |

## Verification
A wrong active-window or enable decision shows up at the ports in the very next cycle, as a wrong index or count on the write pulse. The sweep of every 8-bit source pattern against several vl, vstart and enable combinations makes such an error visible. A pulse suppressed for vl = 0 or vstart >= vl appears as a missing wr_en_o one clock after the strobe. A corrupted holding register appears as a result_o that changes in the idle cycle after each operation.

// File: rtl/vmsr_pkg.sv
package vmsr_pkg;
    typedef enum logic {
        OP_FIRST = 1'b0,
        OP_COUNT = 1'b1
    } vmsr_op_e;
endpackage

// File: rtl/vmsr_active.sv
module vmsr_active #(
    parameter int VLEN = 128,
    parameter int XLEN = 64
) (
    input  logic [VLEN-1:0] src_mask_i,
    input  logic [VLEN-1:0] en_mask_i,
    input  logic            masked_i,
    input  logic [XLEN-1:0] vl_i,
    input  logic [XLEN-1:0] vstart_i,
    output logic [VLEN-1:0] hits_o
);
    localparam logic [XLEN-1:0] VLEN_X = XLEN'(VLEN);

    logic [XLEN-1:0] vl_eff;

    always_comb begin
        vl_eff = (vl_i > VLEN_X) ? VLEN_X : vl_i;
    end

    for (genvar i = 0; i < VLEN; i++) begin : g_elem
        logic in_window;
        logic enabled;
        always_comb begin
            in_window = (XLEN'(i) < vl_eff) && (XLEN'(i) >= vstart_i);
            enabled   = !masked_i || en_mask_i[i];
            hits_o[i] = in_window && enabled && src_mask_i[i];
        end
    end
endmodule

// File: rtl/vmsr_first.sv
module vmsr_first #(
    parameter int VLEN = 128,
    localparam int IW = (VLEN > 1) ? $clog2(VLEN) : 1
) (
    input  logic [VLEN-1:0] hits_i,
    output logic            found_o,
    output logic [IW-1:0]   idx_o
);
    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        for (int i = VLEN - 1; i >= 0; i--) begin
            if (hits_i[i]) begin
                found_o = 1'b1;
                idx_o   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/vmsr_count.sv
module vmsr_count #(
    parameter int VLEN = 128,
    localparam int CW = $clog2(VLEN + 1)
) (
    input  logic [VLEN-1:0] hits_i,
    output logic [CW-1:0]   count_o
);
    always_comb begin
        count_o = '0;
        for (int i = 0; i < VLEN; i++) begin
            count_o = count_o + CW'(hits_i[i]);
        end
    end
endmodule

// File: rtl/vmask_scalar_unit.sv
module vmask_scalar_unit
    import vmsr_pkg::*;
#(
    parameter int VLEN = 128,
    parameter int XLEN = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic            op_i,
    input  logic            masked_i,
    input  logic [VLEN-1:0] src_mask_i,
    input  logic [VLEN-1:0] en_mask_i,
    input  logic [XLEN-1:0] vl_i,
    input  logic [XLEN-1:0] vstart_i,
    output logic [XLEN-1:0] result_o,
    output logic            wr_en_o,
    output logic            evt_exec_o,
    output logic            evt_vl_nz_o
);
    localparam int IW = (VLEN > 1) ? $clog2(VLEN) : 1;
    localparam int CW = $clog2(VLEN + 1);

    typedef struct packed {
        logic [XLEN-1:0] result;
        logic            wr_en;
        logic            evt_exec;
        logic            evt_vl_nz;
    } state_t;

    state_t          st_d, st_q;
    logic [VLEN-1:0] hits;
    logic            found;
    logic [IW-1:0]   first_idx;
    logic [CW-1:0]   pop_cnt;
    vmsr_op_e        op;

    vmsr_active #(.VLEN(VLEN), .XLEN(XLEN)) u_active (
        .src_mask_i (src_mask_i),
        .en_mask_i  (en_mask_i),
        .masked_i   (masked_i),
        .vl_i       (vl_i),
        .vstart_i   (vstart_i),
        .hits_o     (hits)
    );

    vmsr_first #(.VLEN(VLEN)) u_first (
        .hits_i  (hits),
        .found_o (found),
        .idx_o   (first_idx)
    );

    vmsr_count #(.VLEN(VLEN)) u_count (
        .hits_i  (hits),
        .count_o (pop_cnt)
    );

    always_comb begin
        op             = vmsr_op_e'(op_i);
        st_d           = st_q;
        st_d.wr_en     = start_i;
        st_d.evt_exec  = start_i;
        st_d.evt_vl_nz = start_i && (vl_i != '0);
        if (start_i) begin
            if (op == OP_COUNT) begin
                st_d.result = XLEN'(pop_cnt);
            end else if (found) begin
                st_d.result = XLEN'(first_idx);
            end else begin
                st_d.result = '1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign result_o    = st_q.result;
    assign wr_en_o     = st_q.wr_en;
    assign evt_exec_o  = st_q.evt_exec;
    assign evt_vl_nz_o = st_q.evt_vl_nz;
endmodule

// File: rtl/vmsr_checker.sv
module vmsr_checker #(
    parameter int VLEN = 128,
    parameter int XLEN = 64
) (
    input logic            clk,
    input logic            rst_n,
    input logic            start_i,
    input logic            op_i,
    input logic [XLEN-1:0] vl_i,
    input logic [XLEN-1:0] vstart_i,
    input logic [XLEN-1:0] result_o,
    input logic            wr_en_o,
    input logic            evt_exec_o,
    input logic            evt_vl_nz_o
);
    localparam logic [XLEN-1:0] VLEN_X = XLEN'(VLEN);

    AST_WRITE_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> wr_en_o); // R9
    AST_NO_WRITE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !start_i |=> !wr_en_o); // R9
    AST_RESULT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !start_i |=> $stable(result_o)); // R9
    AST_VL0_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && vl_i == '0 && !op_i) |=> (wr_en_o && result_o == '1)); // R4
    AST_VL0_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && vl_i == '0 && op_i) |=> (wr_en_o && result_o == '0)); // R4
    AST_EMPTY_WINDOW_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && vstart_i >= vl_i && op_i) |=> (wr_en_o && result_o == '0)); // R5
    AST_FIRST_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !op_i) |=> (result_o == '1 || result_o < VLEN_X)); // R1
    AST_COUNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && op_i) |=> (result_o <= VLEN_X)); // R3
    AST_EVT_EXEC: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> evt_exec_o); // R10
    AST_EVT_NZ: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (evt_vl_nz_o == $past(vl_i != '0))); // R10
endmodule

bind vmask_scalar_unit vmsr_checker #(.VLEN(VLEN), .XLEN(XLEN)) u_vmsr_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .op_i        (op_i),
    .vl_i        (vl_i),
    .vstart_i    (vstart_i),
    .result_o    (result_o),
    .wr_en_o     (wr_en_o),
    .evt_exec_o  (evt_exec_o),
    .evt_vl_nz_o (evt_vl_nz_o)
);

// File: tb/vmask_scalar_unit_bench.sv
`timescale 1ns/1ps
module vmask_scalar_unit_bench;
    localparam int VL = 8;
    localparam int XL = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic          op_i = 1'b0;
    logic          masked_i = 1'b0;
    logic [VL-1:0] src_mask_i = '0;
    logic [VL-1:0] en_mask_i = '0;
    logic [XL-1:0] vl_i = '0;
    logic [XL-1:0] vstart_i = '0;
    logic [XL-1:0] result_o;
    logic          wr_en_o;
    logic          evt_exec_o;
    logic          evt_vl_nz_o;

    int n_checks = 0;
    int n_fails = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    vmask_scalar_unit #(.VLEN(VL), .XLEN(XL)) u_vmask_scalar_unit (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i),
        .masked_i(masked_i), .src_mask_i(src_mask_i), .en_mask_i(en_mask_i),
        .vl_i(vl_i), .vstart_i(vstart_i), .result_o(result_o),
        .wr_en_o(wr_en_o), .evt_exec_o(evt_exec_o), .evt_vl_nz_o(evt_vl_nz_o)
    );

    function automatic logic [XL-1:0] expect_val(input bit op, input bit msk,
        input logic [VL-1:0] src, input logic [VL-1:0] en, input int vl, input int vs);
        int lim = (vl > VL) ? VL : vl;
        int cnt = 0;
        int first = -1;
        for (int e = 0; e < lim; e++) begin
            if (e >= vs && (!msk || en[e]) && src[e]) begin
                cnt++;
                if (first < 0) first = e;
            end
        end
        if (op) return XL'(cnt);
        return (first < 0) ? '1 : XL'(first);
    endfunction

    task automatic check(input string req, input string what,
                         input logic [XL-1:0] act, input logic [XL-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic run_op(input string req, input bit op, input bit msk,
        input logic [VL-1:0] src, input logic [VL-1:0] en, input int vl, input int vs);
        logic [XL-1:0] exp;
        exp = expect_val(op, msk, src, en, vl, vs);
        @(negedge clk);
        start_i = 1'b1; op_i = op; masked_i = msk; src_mask_i = src;
        en_mask_i = en; vl_i = XL'(vl); vstart_i = XL'(vs);
        @(negedge clk);
        start_i = 1'b0;
        src_mask_i = ~src; vl_i = XL'(VL); vstart_i = '0;
        check(req, "result", result_o, exp);
        check("R9", "wr_en pulse", XL'(wr_en_o), 1);
        check("R10", "evt_exec", XL'(evt_exec_o), 1);
        check("R10", "evt_vl_nz", XL'(evt_vl_nz_o), XL'(vl != 0));
        @(negedge clk);
        check("R9", "wr_en low after pulse", XL'(wr_en_o), 0);
        check("R9", "result held", result_o, exp);
        check("R10", "evt_exec low after pulse", XL'(evt_exec_o), 0);
    endtask

    function automatic string pick_tag(input bit op, input bit msk, input int vl,
                                       input int vs, input logic [XL-1:0] exp);
        if (vl == 0) return "R4";
        if (vs >= vl) return "R5";
        if (vl > VL) return "R8";
        if (msk) return "R7";
        if (op) return "R3";
        return (exp == '1) ? "R2" : "R1";
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        int vls[4] = '{0, 3, 8, 11};
        int vss[3] = '{0, 2, 9};
        repeat (3) @(negedge clk);
        check("R11", "reset wr_en", XL'(wr_en_o), 0);
        check("R11", "reset result", result_o, 0);
        check("R11", "reset evt_exec", XL'(evt_exec_o), 0);
        check("R11", "reset evt_vl_nz", XL'(evt_vl_nz_o), 0);
        rst_n = 1'b1;

        // directed corner cases
        run_op("R6", 1'b0, 1'b0, 8'hFF, 8'h00, 5, 2);
        run_op("R6", 1'b1, 1'b0, 8'hFF, 8'h00, 5, 2);
        run_op("R4", 1'b0, 1'b0, 8'hFF, 8'hFF, 0, 0);
        run_op("R4", 1'b1, 1'b0, 8'hFF, 8'hFF, 0, 0);
        run_op("R5", 1'b0, 1'b0, 8'hFF, 8'hFF, 4, 4);
        run_op("R5", 1'b1, 1'b0, 8'hFF, 8'hFF, 3, 7);
        run_op("R7", 1'b0, 1'b1, 8'h10, 8'h00, 8, 0);
        run_op("R7", 1'b0, 1'b0, 8'h10, 8'h00, 8, 0);
        run_op("R8", 1'b1, 1'b0, 8'h81, 8'h00, 200, 0);
        run_op("R2", 1'b0, 1'b0, 8'h00, 8'hFF, 8, 0);
        run_op("R1", 1'b0, 1'b0, 8'h80, 8'h00, 8, 0);

        // sweep over every source pattern
        for (int s = 0; s < 256; s++) begin
            for (int a = 0; a < 4; a++) begin
                for (int b = 0; b < 3; b++) begin
                    for (int m = 0; m < 2; m++) begin
                        for (int o = 0; o < 2; o++) begin
                            logic [XL-1:0] ex;
                            ex = expect_val(o[0], m[0], VL'(s), 8'hA5, vls[a], vss[b]);
                            run_op(pick_tag(o[0], m[0], vls[a], vss[b], ex),
                                   o[0], m[0], VL'(s), 8'hA5, vls[a], vss[b]);
                        end
                    end
                end
            end
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end
endmodule